// File: doc/BRIEF.md
# Dual-Channel Encoder Phase Counter

This block holds two counting channels for incremental encoders. Each channel takes two phase inputs (A and B) from outside the chip. It passes them through a synchronizer and decodes the edges according to a function code. It then moves a count up or down by one per qualifying edge. The function code picks one of three decoders:
- four-times quadrature, which counts every edge of both phases;
- pulse and direction, which counts rising A and takes its sign from the level of B;
- two-times quadrature, which counts only B transitions and takes its sign from the level of A.

A status bit reports the direction of the last counting step.

Each channel can wrap at a programmable ceiling, or it can run freely over its full width. A shared cascade bit joins the two 16-bit channels into one 32-bit count. In that mode channel 0's inputs and settings drive the count. The upper half advances on the carry or borrow of the lower half, and it reads back through channel 1's count address. Software reads and writes every register over a simple port with separate write and read addresses. Reads are combinational.

Top module: `enc_timer_pair`

## Requirements
- R1: Address bit 3 selects the channel and bits 2:0 select the register: 0 mode, 1 control, 2 status, 3 ceiling, 4 count, 5 shared cascade. After reset, mode and control read 0, ceiling reads 0xFFFF, count reads 0, status reads 0x80 and cascade reads 0.
- R2: Mode low nibble 4 selects four-times quadrature. Each single-phase edge moves the count by one. The sequence AB = 00, 10, 11, 01, 00 counts up and the reverse sequence counts down.
- R3: Mode low nibble 5 selects pulse/direction. Only a rising A counts: up when B is high, down when B is low. Falling A and any B change leave the count unchanged.
- R4: Mode low nibble 7 selects two-times quadrature on B. Only B transitions count: up when the new B equals A, down otherwise. A transitions leave the count unchanged.
- R5: A transition in which A and B change together is ignored in both quadrature functions. Any mode low nibble other than 4, 5 or 7 (6 included) does not count.
- R6: Status bit 7 reads 1 after an up step and 0 after a down step. Writes to the status register have no effect.
- R7: When control bits 7:5 are nonzero, an up step from a count equal to the ceiling gives 0, and a down step from 0 loads the ceiling. When the field is 0, the count wraps freely over its full width.
- R8: A count write takes effect at the next clock edge and wins over a counting step in the same cycle. That step is then lost.
- R9: Control bit 0 enables counting. While it is 0, edges change neither the count nor the status bit.
- R10: With cascade bit 0 set, channel 0 counts 32 bits and its count address reads and writes all 32 bits. The ceiling is {channel 1 ceiling, channel 0 ceiling}. Channel 1's count address shows the upper half, and channel 1's own inputs are ignored.
- R11: Without cascade, channel 1 counts its own inputs with its own settings, independently of channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 2 | Phase A input per channel (asynchronous) |
| b_i | input | 2 | Phase B input per channel (asynchronous) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 32 | Read data for rd_addr_i, combinational |

## Verification
The assertions assume three things about the inputs. First, the phase inputs stay stable long enough that the synchronizer sees each level for at least one clock. Second, only one register write arrives per cycle. Third, software does not change the mode while an edge is in flight through the synchronizer. The stimulus meets all three: it changes one channel's inputs at a falling clock edge and then holds them for four cycles. It issues writes as single-cycle strobes on a quiet bus. The one exception is the override test, which deliberately places a count write in the same cycle as a decoded edge.

// File: rtl/enc_pkg.sv
package enc_pkg;
  localparam logic [3:0] FN_X4   = 4'd4;
  localparam logic [3:0] FN_PDIR = 4'd5;
  localparam logic [3:0] FN_X2B  = 4'd7;

  localparam logic [2:0] REG_MODE = 3'd0;
  localparam logic [2:0] REG_CTRL = 3'd1;
  localparam logic [2:0] REG_STAT = 3'd2;
  localparam logic [2:0] REG_CEIL = 3'd3;
  localparam logic [2:0] REG_CNT  = 3'd4;
  localparam logic [2:0] REG_CASC = 3'd5;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CLR_SEL_LSB  = 5;
  localparam int CLR_SEL_MSB  = 7;
endpackage

// File: rtl/enc_sync.sv
module enc_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign q_o    = s2_q;
  assign prev_o = s3_q;
endmodule

// File: rtl/phase_decode.sv
module phase_decode
  import enc_pkg::*;
(
  input  logic [3:0] fn_i,
  input  logic       a_i,
  input  logic       b_i,
  input  logic       a_prev_i,
  input  logic       b_prev_i,
  output logic       up_o,
  output logic       dn_o
);
  logic da, db, step, dir_up;

  assign da = a_i ^ a_prev_i;
  assign db = b_i ^ b_prev_i;

  always_comb begin
    step   = 1'b0;
    dir_up = 1'b0;
    unique case (fn_i)
      FN_X4: begin
        step   = da ^ db;
        dir_up = da ? (a_i != b_i) : (b_i == a_i);
      end
      FN_PDIR: begin
        step   = da & a_i;
        dir_up = b_i;
      end
      FN_X2B: begin
        step   = db & ~da;
        dir_up = (b_i == a_i);
      end
      default: ;
    endcase
  end

  assign up_o = step & dir_up;
  assign dn_o = step & ~dir_up;
endmodule

// File: rtl/count_unit.sv
module count_unit #(
  parameter int W  = 32,
  parameter int NW = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         wide_i,
  input  logic         up_i,
  input  logic         dn_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] ceil_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_val_i,
  output logic [W-1:0] cnt_o,
  output logic         dir_o
);
  localparam logic [W-1:0] NARROW_MASK = {{(W-NW){1'b0}}, {NW{1'b1}}};

  logic [W-1:0] cnt_q, mask, cur, lim, nxt;
  logic         dir_q;

  assign mask = wide_i ? '1 : NARROW_MASK;
  assign cur  = cnt_q & mask;
  assign lim  = ceil_i & mask;

  always_comb begin
    nxt = cur;
    if (up_i)
      nxt = (clr_en_i && cur == lim) ? '0 : ((cur + 1'b1) & mask);
    else if (dn_i)
      nxt = (cur == '0) ? (clr_en_i ? lim : mask) : (cur - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else if (wr_i) begin
      cnt_q <= wr_val_i & mask;
    end else if (en_i && (up_i || dn_i)) begin
      cnt_q <= nxt;
      dir_q <= up_i;
    end
  end

  assign cnt_o = cnt_q;
  assign dir_o = dir_q;

  assert_wr_override_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_q == $past(wr_val_i & mask));
  assert_hold_disabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !wr_i) |=> (cnt_q == $past(cnt_q)) && (dir_q == $past(dir_q)));
  assert_dir_up_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wr_i && up_i) |=> dir_q);
  assert_dir_dn_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wr_i && dn_i) |=> !dir_q);
endmodule

// File: rtl/enc_timer_pair.sv
module enc_timer_pair
  import enc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    a_i,
  input  logic [1:0]    b_i,
  input  logic          wr_en_i,
  input  logic [3:0]    wr_addr_i,
  input  logic [2*CW-1:0] wr_data_i,
  input  logic [3:0]    rd_addr_i,
  output logic [2*CW-1:0] rd_data_o
);
  localparam int NCH = 2;
  localparam int DW  = 2 * CW;

  logic [7:0]    mode_q [NCH];
  logic [7:0]    ctrl_q [NCH];
  logic [CW-1:0] ceil_q [NCH];
  logic          casc_q;

  logic          wch;
  logic [2:0]    wreg;
  assign wch  = wr_addr_i[3];
  assign wreg = wr_addr_i[2:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NCH; i++) begin
        mode_q[i] <= '0;
        ctrl_q[i] <= '0;
        ceil_q[i] <= '1;
      end
      casc_q <= 1'b0;
    end else if (wr_en_i) begin
      unique case (wreg)
        REG_MODE: mode_q[wch] <= wr_data_i[7:0];
        REG_CTRL: ctrl_q[wch] <= wr_data_i[7:0];
        REG_CEIL: ceil_q[wch] <= wr_data_i[CW-1:0];
        REG_CASC: casc_q      <= wr_data_i[0];
        default: ;
      endcase
    end
  end

  logic [1:0]    sync_w [NCH];
  logic [1:0]    prev_w [NCH];
  logic          up_w   [NCH];
  logic          dn_w   [NCH];
  logic [DW-1:0] cnt_w  [NCH];
  logic          dir_w  [NCH];

  logic          u_en   [NCH];
  logic          u_wide [NCH];
  logic          u_clr  [NCH];
  logic [DW-1:0] u_ceil [NCH];
  logic          u_wr   [NCH];
  logic [DW-1:0] u_wval [NCH];

  logic cnt_wr;
  assign cnt_wr = wr_en_i && (wreg == REG_CNT);

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      u_clr[i] = |ctrl_q[i][CLR_SEL_MSB:CLR_SEL_LSB];
    end
    u_en[0]   = ctrl_q[0][CTRL_RUN_BIT];
    u_wide[0] = casc_q;
    u_ceil[0] = {ceil_q[1], ceil_q[0]};
    u_wr[0]   = cnt_wr && (!wch || casc_q);
    if (!casc_q)  u_wval[0] = {{CW{1'b0}}, wr_data_i[CW-1:0]};
    else if (wch) u_wval[0] = {wr_data_i[CW-1:0], cnt_w[0][CW-1:0]};
    else          u_wval[0] = wr_data_i;
    // channel 1 is idle while it serves as the upper half
    u_en[1]   = ctrl_q[1][CTRL_RUN_BIT] && !casc_q;
    u_wide[1] = 1'b0;
    u_ceil[1] = {{CW{1'b0}}, ceil_q[1]};
    u_wr[1]   = cnt_wr && wch && !casc_q;
    u_wval[1] = {{CW{1'b0}}, wr_data_i[CW-1:0]};
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    enc_sync #(.W(2)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    ({a_i[g], b_i[g]}),
      .q_o    (sync_w[g]),
      .prev_o (prev_w[g])
    );

    phase_decode u_dec (
      .fn_i     (mode_q[g][3:0]),
      .a_i      (sync_w[g][1]),
      .b_i      (sync_w[g][0]),
      .a_prev_i (prev_w[g][1]),
      .b_prev_i (prev_w[g][0]),
      .up_o     (up_w[g]),
      .dn_o     (dn_w[g])
    );

    count_unit #(.W(DW), .NW(CW)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (u_en[g]),
      .wide_i   (u_wide[g]),
      .up_i     (up_w[g]),
      .dn_i     (dn_w[g]),
      .clr_en_i (u_clr[g]),
      .ceil_i   (u_ceil[g]),
      .wr_i     (u_wr[g]),
      .wr_val_i (u_wval[g]),
      .cnt_o    (cnt_w[g]),
      .dir_o    (dir_w[g])
    );

    assert_step_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({up_w[g], dn_w[g]}));
    assert_illegal_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((sync_w[g][1] != prev_w[g][1]) && (sync_w[g][0] != prev_w[g][0]) &&
       (mode_q[g][3:0] != FN_PDIR)) |-> !(up_w[g] || dn_w[g]));
  end

  logic       rch;
  logic [2:0] rreg;
  assign rch  = rd_addr_i[3];
  assign rreg = rd_addr_i[2:0];

  always_comb begin
    rd_data_o = '0;
    unique case (rreg)
      REG_MODE: rd_data_o[7:0]    = mode_q[rch];
      REG_CTRL: rd_data_o[7:0]    = ctrl_q[rch];
      REG_STAT: rd_data_o[7]      = dir_w[rch];
      REG_CEIL: rd_data_o[CW-1:0] = ceil_q[rch];
      REG_CNT: begin
        if (!rch)
          rd_data_o = casc_q ? cnt_w[0] : {{CW{1'b0}}, cnt_w[0][CW-1:0]};
        else
          rd_data_o[CW-1:0] = casc_q ? cnt_w[0][DW-1:CW] : cnt_w[1][CW-1:0];
      end
      REG_CASC: rd_data_o[0] = casc_q;
      default: ;
    endcase
  end
endmodule

// File: tb/enc_timer_pair_tb.sv
module enc_timer_pair_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  a_r = '0, b_r = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0]  q_addr [$];
  logic [31:0] q_exp  [$];
  string       q_tag  [$];

  always #2 clk = ~clk;

  enc_timer_pair u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .a_i       (a_r),
    .b_i       (b_r),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  // monitor: pops expectations and compares against the read port
  always begin
    @(negedge clk);
    if (q_addr.size() > 0) begin
      logic [3:0]  ad;
      logic [31:0] ex;
      string       tg;
      ad = q_addr.pop_front();
      ex = q_exp.pop_front();
      tg = q_tag.pop_front();
      rd_addr = ad;
      #1;
      checks++;
      if (rd_data !== ex) begin
        errors++;
        $display("FAIL %s addr=%h actual=%h expected=%h", tg, ad, rd_data, ex);
      end
    end
  end

  task automatic expect_rd(input logic [3:0] ad, input logic [31:0] ex, input string tg);
    q_addr.push_back(ad);
    q_exp.push_back(ex);
    q_tag.push_back(tg);
    wait (q_addr.size() == 0);
    #2;
  endtask

  task automatic wreg(input logic [3:0] ad, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ad; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_in(input int ch, input logic a, input logic b);
    @(negedge clk);
    a_r[ch] = a; b_r[ch] = b;
    repeat (4) @(negedge clk);
  endtask

  // one quadrature step; sequence 00,10,11,01 is upward
  task automatic quad(input int ch, input bit up);
    logic [1:0] s, n;
    s = {a_r[ch], b_r[ch]};
    if (up) n = (s == 2'b00) ? 2'b10 : (s == 2'b10) ? 2'b11 : (s == 2'b11) ? 2'b01 : 2'b00;
    else    n = (s == 2'b00) ? 2'b01 : (s == 2'b01) ? 2'b11 : (s == 2'b11) ? 2'b10 : 2'b00;
    set_in(ch, n[1], n[0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    expect_rd(4'h0, 32'h0, "R1 mode reset");
    expect_rd(4'h1, 32'h0, "R1 ctrl reset");
    expect_rd(4'h3, 32'hFFFF, "R1 ceiling reset");
    expect_rd(4'h4, 32'h0, "R1 count reset");
    expect_rd(4'h2, 32'h80, "R1 status reset");
    expect_rd(4'h5, 32'h0, "R1 cascade reset");

    wreg(4'h0, 32'h4);
    wreg(4'h1, 32'h1);
    repeat (4) quad(0, 1'b1);
    expect_rd(4'h4, 32'd4, "R2 x4 up");
    expect_rd(4'h2, 32'h80, "R6 status up");
    repeat (4) quad(0, 1'b0);
    expect_rd(4'h4, 32'd0, "R2 x4 down");
    expect_rd(4'h2, 32'h00, "R6 status down");
    quad(0, 1'b0);
    expect_rd(4'h4, 32'hFFFF, "R7 free wrap down");
    quad(0, 1'b1);
    expect_rd(4'h4, 32'h0, "R7 free wrap up");
    set_in(0, 1'b1, 1'b1);
    expect_rd(4'h4, 32'h0, "R5 illegal 00-11");
    set_in(0, 1'b0, 1'b0);
    expect_rd(4'h4, 32'h0, "R5 illegal 11-00");
    wreg(4'h2, 32'h0);
    expect_rd(4'h2, 32'h80, "R6 status write ignored");

    wreg(4'h0, 32'h5);
    set_in(0, 1'b0, 1'b1);
    expect_rd(4'h4, 32'h0, "R3 B change ignored");
    set_in(0, 1'b1, 1'b1);
    expect_rd(4'h4, 32'h1, "R3 rise A with B high");
    set_in(0, 1'b0, 1'b1);
    expect_rd(4'h4, 32'h1, "R3 fall A ignored");
    set_in(0, 1'b0, 1'b0);
    set_in(0, 1'b1, 1'b0);
    expect_rd(4'h4, 32'h0, "R3 rise A with B low");
    set_in(0, 1'b0, 1'b0);

    wreg(4'h0, 32'h7);
    set_in(0, 1'b0, 1'b1);
    expect_rd(4'h4, 32'hFFFF, "R4 B rise A low down");
    set_in(0, 1'b0, 1'b0);
    expect_rd(4'h4, 32'h0, "R4 B fall A low up");
    set_in(0, 1'b1, 1'b0);
    expect_rd(4'h4, 32'h0, "R4 A change ignored");
    set_in(0, 1'b1, 1'b1);
    expect_rd(4'h4, 32'h1, "R4 B rise A high up");

    wreg(4'h0, 32'h6);
    set_in(0, 1'b0, 1'b1);
    expect_rd(4'h4, 32'h1, "R5 mode 6 no count");

    wreg(4'h0, 32'h4);
    wreg(4'h3, 32'd5);
    wreg(4'h1, 32'h21);
    wreg(4'h4, 32'd4);
    expect_rd(4'h4, 32'd4, "R8 count write");
    quad(0, 1'b1);
    expect_rd(4'h4, 32'd5, "R7 reach ceiling");
    quad(0, 1'b1);
    expect_rd(4'h4, 32'd0, "R7 clear at ceiling");
    quad(0, 1'b1);
    quad(0, 1'b0);
    quad(0, 1'b0);
    expect_rd(4'h4, 32'd5, "R7 down from 0 loads ceiling");

    // state is 00: step 00->10 lands with a count write in the same cycle
    @(negedge clk);
    a_r[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'h4; wr_data = 32'd2;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    expect_rd(4'h4, 32'd2, "R8 write wins over step");

    wreg(4'h1, 32'h20);
    quad(0, 1'b1);
    expect_rd(4'h4, 32'd2, "R9 disabled holds count");
    expect_rd(4'h2, 32'h00, "R9 disabled holds status");

    wreg(4'h8, 32'h4);
    wreg(4'h9, 32'h1);
    set_in(1, 1'b1, 1'b0);
    expect_rd(4'hC, 32'd1, "R11 channel 1 counts");
    expect_rd(4'h4, 32'd2, "R11 channel 0 untouched");

    wreg(4'h5, 32'h1);
    wreg(4'h1, 32'h1);
    wreg(4'h3, 32'hFFFF);
    wreg(4'h4, 32'h0000FFFF);
    quad(0, 1'b1);
    expect_rd(4'h4, 32'h00010000, "R10 carry into upper");
    expect_rd(4'hC, 32'h1, "R10 upper via channel 1");
    quad(0, 1'b0);
    expect_rd(4'h4, 32'h0000FFFF, "R10 borrow from upper");
    set_in(1, 1'b1, 1'b1);
    expect_rd(4'hC, 32'h0, "R10 channel 1 inputs ignored");
    wreg(4'h1, 32'h21);
    wreg(4'h3, 32'h0);
    wreg(4'hB, 32'h1);
    quad(0, 1'b1);
    expect_rd(4'h4, 32'h00010000, "R10 reach 32-bit ceiling");
    quad(0, 1'b1);
    expect_rd(4'h4, 32'h0, "R10 clear at 32-bit ceiling");
    quad(0, 1'b0);
    expect_rd(4'h4, 32'h00010000, "R10 down loads 32-bit ceiling");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule